// File: doc/BRIEF.md
# Interprocessor Packet Receive Controller

This block is the receiving half of a dual-bus processor-to-processor link. Packets arrive one word per handshake on a single ingress port, each tagged with the bus it came over and the number of the sending processor. Every pair of (bus, sender) owns a private one-packet holding slot. While a packet streams in, its trailing check word is compared with the running XOR of the payload. A packet that passes is kept in its slot until the drain engine copies it to local memory.

The copy is steered by a receive table that holds one entry per (bus, sender). Each entry holds the next destination address and the number of words still expected. After each copied packet the entry moves forward. Software is told only when an entry's expected count reaches zero, so a long message costs one interrupt and not one per packet. Packets with a bad check word, or packets aimed at an entry that expects nothing, are dropped and recorded.

The table is loaded through a simple write strobe. The memory side is a valid/ready write port. The ingress side stalls a sender whose slot still holds a packet that has not been copied out.

Top module: `ipc_rx_ctrl`

## Requirements
- R1: A packet is 16 words accepted on cycles with in_valid and in_ready both high: words 0..14 are payload and word 15 is the check word, equal to the bitwise XOR of the 15 payload words. The channel is taken from in_bus/in_src on word 0, and its index is in_bus*16+in_src.
- R2: The payload of a good packet is offered on mem_valid/mem_addr/mem_data at ascending addresses from the channel's table address. Each write is held unchanged until mem_ready is seen high.
- R3: After a good packet the channel's table address rises by the number of words written and its count falls by the same amount, so the next packet continues where the last one stopped.
- R4: Only min(15, remaining count) payload words are written. Trailing words beyond the count are never written.
- R5: irq pulses high for exactly one cycle, with irq_bus/irq_src naming the channel, when a channel's count reaches zero. A packet that leaves the count non-zero raises no irq.
- R6: A check-word mismatch sets the sticky bit lrc_err[bus*16+src] at the edge that accepts word 15. Nothing is written and the table entry is unchanged.
- R7: A good packet whose channel count is zero is dropped without any write or irq, and unexp_cnt increments (saturating).
- R8: Each channel has its own holding slot: in_ready is low only while the addressed channel's slot still holds an uncopied packet, and other channels keep accepting.
- R9: The first memory write of a packet is offered in the second cycle after the edge that accepts its check word.
- R10: A cycle with cfg_we high loads cfg_addr and cfg_cnt into the entry of channel cfg_bus*16+cfg_src. Counts up to 65535 are held.
- R11: After reset in_ready is high, mem_valid and irq are low, lrc_err is all zero and unexp_cnt is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Ingress word valid |
| in_ready | output | 1 | Ingress word accepted this cycle when high with in_valid |
| in_bus | input | 1 | Bus the packet arrived on (sampled on word 0) |
| in_src | input | 4 | Sending processor number (sampled on word 0) |
| in_data | input | 16 | Ingress word |
| cfg_we | input | 1 | Receive-table entry write strobe |
| cfg_bus | input | 1 | Bus part of the entry index |
| cfg_src | input | 4 | Sender part of the entry index |
| cfg_addr | input | 16 | Destination address to load |
| cfg_cnt | input | 16 | Expected word count to load |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| mem_addr | output | 16 | Memory write address |
| mem_data | output | 16 | Memory write data |
| irq | output | 1 | One-cycle message-complete pulse |
| irq_bus | output | 1 | Bus of the completed message |
| irq_src | output | 4 | Sender of the completed message |
| lrc_err | output | 32 | Sticky check-word error flag per channel |
| unexp_cnt | output | 8 | Saturating count of packets sent to an idle entry |

## Verification
The error flags and the dropped-packet count change at the same edge that accepts a packet's check word. The bench reads them at the falling edge right after that edge. The first memory write appears two edges after the check word, so the bench sees mem_valid still low at the first falling edge and high, with the table address on mem_addr, at the next one. Each later write follows the edge that accepted the previous one. irq is high only in the cycle after the final write is accepted, so a monitor two time units past each falling edge counts pulses and records writes where mem_ready and mem_valid are both stable. The totals are compared after a drain window that is long enough even under random memory stalls.

// File: rtl/ipc_rx_pkg.sv
package ipc_rx_pkg;
    typedef enum logic [0:0] {
        DR_IDLE  = 1'b0,
        DR_WRITE = 1'b1
    } drain_st_e;
endpackage

// File: rtl/ipc_rx_pick.sv
// Lowest-index request wins.
module ipc_rx_pick #(
    parameter int N = 32,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/ipc_rx_fill.sv
// Ingress sequencer: counts words, latches the channel, folds the XOR check.
module ipc_rx_fill #(
    parameter int DATA_W    = 16,
    parameter int CH_W      = 5,
    parameter int PKT_WORDS = 16,
    localparam int IDX_W = $clog2(PKT_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_ch,
    input  logic [DATA_W-1:0] in_data,
    input  logic              sel_full,
    output logic [CH_W-1:0]   sel_ch,
    output logic              in_ready,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              done,
    output logic              done_ok
);
    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [CH_W-1:0]   ch;
        logic [DATA_W-1:0] lrc;
    } fill_t;

    fill_t s_d, s_q;
    logic  acc, last;

    always_comb begin
        s_d      = s_q;
        sel_ch   = (s_q.idx == '0) ? in_ch : s_q.ch;
        in_ready = !sel_full;
        acc      = in_valid && in_ready;
        last     = (s_q.idx == IDX_W'(PKT_WORDS - 1));
        wr_en    = acc && !last;
        wr_idx   = s_q.idx;
        done     = acc && last;
        done_ok  = (s_q.lrc == in_data);
        if (acc) begin
            if (last) begin
                s_d.idx = '0;
                s_d.lrc = '0;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
                s_d.lrc = s_q.lrc ^ in_data;
                s_d.ch  = sel_ch;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/ipc_rx_ctrl.sv
module ipc_rx_ctrl #(
    parameter int NUM_SRC   = 16,
    parameter int NUM_BUS   = 2,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 16,
    parameter int CNT_W     = 16,
    parameter int PKT_WORDS = 16,
    parameter int ERRC_W    = 8,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int BUS_W  = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
    localparam int NUM_CH = NUM_SRC * NUM_BUS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BUS_W-1:0]  in_bus,
    input  logic [SRC_W-1:0]  in_src,
    input  logic [DATA_W-1:0] in_data,
    input  logic              cfg_we,
    input  logic [BUS_W-1:0]  cfg_bus,
    input  logic [SRC_W-1:0]  cfg_src,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_cnt,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              irq,
    output logic [BUS_W-1:0]  irq_bus,
    output logic [SRC_W-1:0]  irq_src,
    output logic [NUM_CH-1:0] lrc_err,
    output logic [ERRC_W-1:0] unexp_cnt
);
    import ipc_rx_pkg::*;

    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int INFO  = PKT_WORDS - 1;
    localparam int IDX_W = $clog2(PKT_WORDS);

    typedef struct packed {
        logic [NUM_CH-1:0][INFO-1:0][DATA_W-1:0] slot;
        logic [NUM_CH-1:0]                       full;
        logic [NUM_CH-1:0][ADDR_W-1:0]           taddr;
        logic [NUM_CH-1:0][CNT_W-1:0]            tcnt;
        logic [NUM_CH-1:0]                       lerr;
        logic [ERRC_W-1:0]                       unexp;
        drain_st_e                               st;
        logic [CH_W-1:0]                         dch;
        logic [IDX_W-1:0]                        k;
        logic [IDX_W-1:0]                        n;
        logic                                    irq;
        logic [CH_W-1:0]                         ich;
    } rx_t;

    rx_t s_d, s_q;

    logic [CH_W-1:0]  in_ch, cfg_ch, f_ch;
    logic             f_wr_en, f_done, f_ok;
    logic [IDX_W-1:0] f_idx;
    logic             pk_any;
    logic [CH_W-1:0]  pk_idx;
    logic [IDX_W-1:0] nn;

    assign in_ch  = CH_W'(in_bus) * CH_W'(NUM_SRC) + CH_W'(in_src);
    assign cfg_ch = CH_W'(cfg_bus) * CH_W'(NUM_SRC) + CH_W'(cfg_src);

    ipc_rx_fill #(
        .DATA_W   (DATA_W),
        .CH_W     (CH_W),
        .PKT_WORDS(PKT_WORDS)
    ) i_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_ch   (in_ch),
        .in_data (in_data),
        .sel_full(s_q.full[f_ch]),
        .sel_ch  (f_ch),
        .in_ready(in_ready),
        .wr_en   (f_wr_en),
        .wr_idx  (f_idx),
        .done    (f_done),
        .done_ok (f_ok)
    );

    ipc_rx_pick #(.N(NUM_CH)) i_pick (
        .req(s_q.full),
        .any(pk_any),
        .idx(pk_idx)
    );

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        nn      = (s_q.tcnt[pk_idx] >= CNT_W'(INFO)) ? IDX_W'(INFO)
                                                     : IDX_W'(s_q.tcnt[pk_idx]);

        // ingress: payload into the channel slot, verdict on the check word
        if (f_wr_en) s_d.slot[f_ch][f_idx] = in_data;
        if (f_done) begin
            if (!f_ok) begin
                s_d.lerr[f_ch] = 1'b1;
            end else if (s_q.tcnt[f_ch] == '0) begin
                if (s_q.unexp != '1) s_d.unexp = s_q.unexp + 1'b1;
            end else begin
                s_d.full[f_ch] = 1'b1;
            end
        end

        // table load; a drain completion below overrides it
        if (cfg_we) begin
            s_d.taddr[cfg_ch] = cfg_addr;
            s_d.tcnt[cfg_ch]  = cfg_cnt;
        end

        // drain one slot at a time
        unique case (s_q.st)
            DR_IDLE: begin
                if (pk_any) begin
                    s_d.dch = pk_idx;
                    s_d.k   = '0;
                    s_d.n   = nn;
                    if (nn == '0) s_d.full[pk_idx] = 1'b0;
                    else          s_d.st = DR_WRITE;
                end
            end
            DR_WRITE: begin
                if (mem_ready) begin
                    if (s_q.k == s_q.n - 1'b1) begin
                        s_d.taddr[s_q.dch] = s_q.taddr[s_q.dch] + ADDR_W'(s_q.n);
                        s_d.tcnt[s_q.dch]  = s_q.tcnt[s_q.dch] - CNT_W'(s_q.n);
                        s_d.full[s_q.dch]  = 1'b0;
                        s_d.st             = DR_IDLE;
                        if (s_q.tcnt[s_q.dch] == CNT_W'(s_q.n)) begin
                            s_d.irq = 1'b1;
                            s_d.ich = s_q.dch;
                        end
                    end else begin
                        s_d.k = s_q.k + 1'b1;
                    end
                end
            end
            default: s_d.st = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_valid = (s_q.st == DR_WRITE);
    assign mem_addr  = s_q.taddr[s_q.dch] + ADDR_W'(s_q.k);
    assign mem_data  = s_q.slot[s_q.dch][s_q.k];
    assign irq       = s_q.irq;
    assign irq_bus   = BUS_W'(s_q.ich / CH_W'(NUM_SRC));
    assign irq_src   = SRC_W'(s_q.ich % CH_W'(NUM_SRC));
    assign lrc_err   = s_q.lerr;
    assign unexp_cnt = s_q.unexp;
endmodule

// File: rtl/ipc_rx_ctrl_chk.sv
module ipc_rx_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int NUM_CH = 32,
    parameter int ERRC_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic              irq,
    input logic [NUM_CH-1:0] lrc_err,
    input logic [ERRC_W-1:0] unexp_cnt
);
    // R2
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R5
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R5
    irq_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !mem_valid);

    // R6
    lrc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lrc_err & $past(lrc_err)) == $past(lrc_err)));

    // R7
    unexp_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (unexp_cnt >= $past(unexp_cnt)));
endmodule

bind ipc_rx_ctrl ipc_rx_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NUM_CH(NUM_CH),
    .ERRC_W(ERRC_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_valid(mem_valid),
    .mem_ready(mem_ready),
    .mem_addr (mem_addr),
    .mem_data (mem_data),
    .irq      (irq),
    .lrc_err  (lrc_err),
    .unexp_cnt(unexp_cnt)
);

// File: tb/test_ipc_rx_ctrl.sv
module test_ipc_rx_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [0:0]  in_bus = '0;
    logic [3:0]  in_src = '0;
    logic [15:0] in_data = '0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_bus = '0;
    logic [3:0]  cfg_src = '0;
    logic [15:0] cfg_addr = '0;
    logic [15:0] cfg_cnt = '0;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [15:0] mem_addr;
    logic [15:0] mem_data;
    logic        irq;
    logic [0:0]  irq_bus;
    logic [3:0]  irq_src;
    logic [31:0] lrc_err;
    logic [7:0]  unexp_cnt;

    int n_chk = 0;
    int n_fail = 0;
    int wr_cnt = 0;
    int irq_cnt = 0;
    int irq_b = 0;
    int irq_s = 0;
    logic        hold = 1'b0;
    logic        stall = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    logic [15:0] bmem [0:1023];

    always #4 clk = ~clk;

    ipc_rx_ctrl i_ipc_rx_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_bus(in_bus), .in_src(in_src), .in_data(in_data),
        .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_src(cfg_src), .cfg_addr(cfg_addr), .cfg_cnt(cfg_cnt),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .irq(irq), .irq_bus(irq_bus), .irq_src(irq_src), .lrc_err(lrc_err), .unexp_cnt(unexp_cnt)
    );

    always @(negedge clk) begin
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready <= hold ? 1'b0 : (stall ? lfsr[0] : 1'b1);
    end

    always begin
        @(negedge clk);
        #2;
        if (rst_n && mem_valid && mem_ready) begin
            bmem[mem_addr[9:0]] = mem_data;
            wr_cnt++;
        end
        if (rst_n && irq) begin
            irq_cnt++;
            irq_b = int'(irq_bus);
            irq_s = int'(irq_src);
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    task automatic chk_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pw(input logic [15:0] seed, input int i);
        return seed * 16'd37 + 16'(i) * 16'd101 + 16'h05a5;
    endfunction

    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic clr_mem();
        for (int i = 0; i < 1024; i++) bmem[i] = '0;
    endtask

    task automatic cfg(input logic b, input logic [3:0] s, input logic [15:0] a, input logic [15:0] c);
        cfg_we = 1'b1; cfg_bus = b; cfg_src = s; cfg_addr = a; cfg_cnt = c;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // returns at the falling edge right after the check word was accepted
    task automatic send_pkt(input logic b, input logic [3:0] s, input logic [15:0] seed, input bit bad);
        logic [15:0] x;
        x = '0;
        for (int i = 0; i < 16; i++) begin
            logic [15:0] w;
            if (i < 15) begin
                w = pw(seed, i);
                x = x ^ w;
            end else begin
                w = bad ? ~x : x;
            end
            in_valid = 1'b1; in_bus = b; in_src = s; in_data = w;
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic chk_mem(input string req, input int base, input logic [15:0] seed0, input int nw);
        int bad;
        bad = 0;
        for (int i = 0; i < nw; i++) begin
            logic [15:0] e;
            e = pw(seed0 + 16'(i / 15), i % 15);
            if (bmem[10'(base + i)] !== e) bad++;
        end
        chk_eq(req, bad, 0);
    endtask

    task automatic t_reset();
        #2;
        chk_eq("R11 in_ready after reset", int'(in_ready), 1);
        chk_eq("R11 mem_valid after reset", int'(mem_valid), 0);
        chk_eq("R11 irq after reset", int'(irq), 0);
        chk_eq("R11 lrc_err after reset", int'(lrc_err), 0);
        chk_eq("R11 unexp_cnt after reset", int'(unexp_cnt), 0);
    endtask

    task automatic t_basic();
        int w0, i0;
        clr_mem(); w0 = wr_cnt; i0 = irq_cnt;
        cfg(1'b0, 4'd3, 16'h0100, 16'd30);
        send_pkt(1'b0, 4'd3, 16'd10, 1'b0);
        #2;
        chk_eq("R9 no write one cycle after check word", int'(mem_valid), 0);
        @(negedge clk); #2;
        chk_eq("R9 write offered two cycles after check word", int'(mem_valid), 1);
        chk_eq("R2 first address is table address", int'(mem_addr), 16'h0100);
        idle(30);
        chk_eq("R5 no irq mid-message", irq_cnt - i0, 0);
        chk_eq("R2 writes of first packet", wr_cnt - w0, 15);
        send_pkt(1'b0, 4'd3, 16'd11, 1'b0);
        idle(30);
        chk_eq("R5 one irq at message end", irq_cnt - i0, 1);
        chk_eq("R5 irq_bus", irq_b, 0);
        chk_eq("R5 irq_src", irq_s, 3);
        chk_eq("R1 total writes", wr_cnt - w0, 30);
        chk_mem("R3 two packets contiguous in memory", 16'h0100, 16'd10, 30);
    endtask

    task automatic t_partial();
        int w0, i0, extra;
        clr_mem(); w0 = wr_cnt; i0 = irq_cnt;
        cfg(1'b1, 4'd7, 16'h0200, 16'd20);
        send_pkt(1'b1, 4'd7, 16'd20, 1'b0);
        send_pkt(1'b1, 4'd7, 16'd21, 1'b0);
        idle(40);
        chk_eq("R4 only counted words written", wr_cnt - w0, 20);
        chk_mem("R4 counted words content", 16'h0200, 16'd20, 20);
        extra = 0;
        for (int i = 20; i < 30; i++) if (bmem[10'(16'h0200 + i)] !== 16'h0000) extra++;
        chk_eq("R4 trailing words untouched", extra, 0);
        chk_eq("R5 irq on partial end", irq_cnt - i0, 1);
        chk_eq("R5 irq_bus partial", irq_b, 1);
        chk_eq("R5 irq_src partial", irq_s, 7);
    endtask

    task automatic t_lrc();
        int w0, i0;
        clr_mem(); w0 = wr_cnt; i0 = irq_cnt;
        cfg(1'b1, 4'd5, 16'h0300, 16'd15);
        send_pkt(1'b1, 4'd5, 16'd30, 1'b1);
        #2;
        chk_eq("R6 error flag set at check word", int'(lrc_err), 32'h0020_0000);
        idle(30);
        chk_eq("R6 no writes for bad packet", wr_cnt - w0, 0);
        chk_eq("R6 no irq for bad packet", irq_cnt - i0, 0);
        send_pkt(1'b1, 4'd5, 16'd31, 1'b0);
        idle(30);
        chk_mem("R6 table not advanced by bad packet", 16'h0300, 16'd31, 15);
        chk_eq("R6 good packet completes message", irq_cnt - i0, 1);
        chk_eq("R6 flag sticky", int'(lrc_err), 32'h0020_0000);
    endtask

    task automatic t_unexp();
        int w0, i0;
        w0 = wr_cnt; i0 = irq_cnt;
        send_pkt(1'b0, 4'd9, 16'd40, 1'b0);
        #2;
        chk_eq("R7 unexpected counted", int'(unexp_cnt), 1);
        send_pkt(1'b0, 4'd3, 16'd41, 1'b0);
        idle(30);
        chk_eq("R7 finished entry rejects packet", int'(unexp_cnt), 2);
        chk_eq("R7 no writes", wr_cnt - w0, 0);
        chk_eq("R7 no irq", irq_cnt - i0, 0);
    endtask

    task automatic t_bufs();
        int w0, i0;
        clr_mem(); w0 = wr_cnt; i0 = irq_cnt;
        hold = 1'b1;
        cfg(1'b0, 4'd2, 16'h0400, 16'd15);
        cfg(1'b1, 4'd2, 16'h0500, 16'd15);
        send_pkt(1'b0, 4'd2, 16'd50, 1'b0);
        send_pkt(1'b1, 4'd2, 16'd51, 1'b0);
        in_valid = 1'b1; in_bus = 1'b0; in_src = 4'd2; in_data = 16'h1234;
        #1;
        chk_eq("R8 stall on occupied slot bus0", int'(in_ready), 0);
        in_bus = 1'b1;
        #1;
        chk_eq("R8 stall on occupied slot bus1", int'(in_ready), 0);
        in_bus = 1'b0; in_src = 4'd4;
        #1;
        chk_eq("R8 free slot still ready", int'(in_ready), 1);
        in_valid = 1'b0;
        @(negedge clk);
        hold = 1'b0;
        idle(50);
        chk_eq("R8 both slots drained", wr_cnt - w0, 30);
        chk_mem("R8 bus0 data", 16'h0400, 16'd50, 15);
        chk_mem("R8 bus1 data", 16'h0500, 16'd51, 15);
        chk_eq("R8 two irqs", irq_cnt - i0, 2);
    endtask

    task automatic t_stall();
        int w0, i0;
        clr_mem(); w0 = wr_cnt; i0 = irq_cnt;
        stall = 1'b1;
        cfg(1'b0, 4'd12, 16'h0600, 16'd45);
        send_pkt(1'b0, 4'd12, 16'd60, 1'b0);
        send_pkt(1'b0, 4'd12, 16'd61, 1'b0);
        send_pkt(1'b0, 4'd12, 16'd62, 1'b0);
        idle(200);
        stall = 1'b0;
        chk_eq("R2 writes under stalls", wr_cnt - w0, 45);
        chk_mem("R2 data under stalls", 16'h0600, 16'd60, 45);
        chk_eq("R5 one irq under stalls", irq_cnt - i0, 1);
    endtask

    task automatic t_max();
        int w0, i0;
        clr_mem(); w0 = wr_cnt; i0 = irq_cnt;
        cfg(1'b1, 4'd15, 16'h0700, 16'd65535);
        send_pkt(1'b1, 4'd15, 16'd70, 1'b0);
        idle(30);
        chk_eq("R10 max count packet writes", wr_cnt - w0, 15);
        chk_eq("R10 max count no irq", irq_cnt - i0, 0);
        chk_mem("R10 max count data", 16'h0700, 16'd70, 15);
        cfg(1'b1, 4'd15, 16'h0780, 16'd15);
        send_pkt(1'b1, 4'd15, 16'd72, 1'b0);
        idle(30);
        chk_mem("R10 reload address used", 16'h0780, 16'd72, 15);
        chk_eq("R10 reload count completes", irq_cnt - i0, 1);
    endtask

    initial begin
        clr_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        @(negedge clk);
        t_basic();
        t_partial();
        t_lrc();
        t_unexp();
        t_bufs();
        t_stall();
        t_max();
        summary();
        $finish;
    end
endmodule